// File: doc/BRIEF.md
# Freezable Event Counter Bank

This block is a performance monitor for a memory controller. It holds eleven counters behind a word-addressed 32-bit register port. Counter 0 is a 64-bit cycle counter that advances on every clock unless it is frozen. Counters 1 to 10 are 32 bits wide. Each of them picks one event line through a 7-bit code and adds one on every cycle in which that line is high. One set of event lines is shared by all the 32-bit counters. Every counter also has its own private set of event lines.

Counting stops while the global freeze-all bit or the counter's own freeze bit is set. It resumes under the current settings as soon as both are clear. A counter overflows when its top bit goes from 0 to 1 through an increment. The overflow is qualified when the global interrupt enable, the global freeze-on-condition enable and that counter's condition enable are all set. A qualified overflow raises a level interrupt and sets the freeze-all bit in hardware, so every counter holds the value it reached.

Software services the interrupt in two steps, which may come in either order. It clears freeze-all, and it clears the top bit of the counter that overflowed. The interrupt drops only after both steps are done.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. Addresses that decode to no register read 0.
- R2: Counter 0 advances by one on every clock while neither freeze applies. Its low word is at 0x58 and its high word at 0x5C, and a carry out of the low word reaches the high word.
- R3: Counter n (1 to 10) adds one per cycle in which its selected line is high and it is not frozen. The 7-bit code is bits 22:16 of its control word A at 0x50+0x10*n. Code c in 12..63 selects `ref_evt[c-12]`. Code c in 64..71 selects `spec_evt[(n-1)*8 + c-64]`, a line that belongs to that counter alone.
- R4: While freeze-all (bit 31 of the global word at 0x40) or the local freeze (bit 31 of control word A) is set, the counter holds its value. Clearing the bit resumes counting on the next cycle.
- R5: For counters 1 to 10, codes 0..11 and 72..127 count nothing, whatever the event inputs do.
- R6: A write to a count word (0x58+0x10*n) loads the written value, even if the counter is frozen. The write wins over an increment in the same cycle.
- R7: A qualified overflow needs bit 30 (interrupt enable) and bit 29 (freeze-on-condition) of the global word, plus bit 26 of the counter's control word A. When one occurs, `irq` goes to 1 and bit 31 of the global word becomes 1 on the same edge that sets the top bit. Counting then stops.
- R8: An overflow that lacks any of the three enables leaves `irq` at 0 and does not set freeze-all.
- R9: `irq` stays 1 until freeze-all has been cleared and the overflowed counter's top bit reads 0. It then drops one cycle later.
- R10: Control word B (0x54+0x10*n) is 32-bit read/write storage with no effect on any other register. Control word A reads back only bits 31, 26 and 22:16, and the global word reads back only bits 31:29. All other bits read 0.
- R11: Counter 0 overflows at bit 63, with the same qualification and freeze as R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| addr | input | 8 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ref_evt | input | 52 | Shared event pulses for codes 12..63 |
| spec_evt | input | 80 | Per-counter event pulses, 8 for each of counters 1..10 |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench probes the decoding of event codes at both ends of the shared range and at both ends of the private range. A design that offsets the index by one, or that lets one counter see another counter's private lines, gives the wrong count. Codes just outside the valid ranges are driven with every input high, to catch a decoder that lets an unmapped code fall through to a real line.

The bench also checks the overflow path in several ways:
- It removes one enable at a time and confirms that no interrupt or freeze follows.
- It clears freeze-all and the top bit in both orders, to catch an interrupt that drops too early.
- It starts counter 0 just below bit 63, to catch a carry that never crosses the word boundary.

A write landing in the same cycle as an event pulse must leave exactly the written value.

// File: rtl/evt_ctr_pkg.sv
// Package: address map, bit positions and register kinds of the event counter bank.
// Assumes a 32-bit data word and word-aligned byte addresses.
package evt_ctr_pkg;

    localparam int GCTL_ADDR  = 'h40;   // global control word
    localparam int CTR_BASE   = 'h50;   // control word A of counter 0
    localparam int CTR_STRIDE = 'h10;   // bytes per counter group

    localparam int GB_FAC   = 31;       // global freeze-all
    localparam int GB_PMIE  = 30;       // global interrupt enable
    localparam int GB_FCECE = 29;       // global freeze-on-condition enable

    localparam int LB_FC    = 31;       // local freeze
    localparam int LB_CE    = 26;       // local condition enable
    localparam int LB_EVT   = 16;       // low bit of the event code field

    localparam int REF_LO   = 12;       // first shared event code
    localparam int REF_HI   = 63;       // last shared event code
    localparam int N_REF    = REF_HI - REF_LO + 1;
    localparam int SPEC_LO  = 64;       // first private event code

    typedef enum logic [2:0] {
        RK_NONE,
        RK_GCTL,
        RK_CA,
        RK_CB,
        RK_CNT,
        RK_CNTHI
    } reg_kind_e;

    typedef struct packed {
        logic       fc;
        logic       ce;
        logic [6:0] evt;
    } lca_t;

endpackage

// File: rtl/ecb_addr_dec.sv
// Address decoder: maps a byte address to a register kind and a counter index.
// Assumes word-aligned access. Misaligned or unmapped addresses decode to RK_NONE.
// The high count word exists only for counter 0.
module ecb_addr_dec
    import evt_ctr_pkg::*;
#(
    parameter int N_CTR  = 11,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = $clog2(N_CTR)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam int SPAN = N_CTR * CTR_STRIDE;

    // Classify the address and extract the counter index.
    always_comb begin
        int a;
        int off;
        a    = int'(addr);
        off  = a - CTR_BASE;
        kind = RK_NONE;
        idx  = '0;
        if (a == GCTL_ADDR) begin
            kind = RK_GCTL;
        end else if (off >= 0 && off < SPAN && (a % 4) == 0) begin
            idx = IDX_W'(off / CTR_STRIDE);
            case ((off % CTR_STRIDE) / 4)
                0:       kind = RK_CA;
                1:       kind = RK_CB;
                2:       kind = RK_CNT;
                default: kind = (off < CTR_STRIDE) ? RK_CNTHI : RK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ecb_evt_sel.sv
// Event selector: picks one pulse from the shared or private lines by code.
// A code outside both ranges selects nothing.
module ecb_evt_sel
    import evt_ctr_pkg::*;
#(
    parameter int EVT_W  = 7,
    parameter int N_SPEC = 8
) (
    input  logic [EVT_W-1:0]  code,
    input  logic [N_REF-1:0]  ref_evt,
    input  logic [N_SPEC-1:0] spec_evt,
    output logic              hit
);

    // Compare the code against every mapped value; at most one matches.
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < N_REF; k++) begin
            if (int'(code) == REF_LO + k) hit = hit | ref_evt[k];
        end
        for (int k = 0; k < N_SPEC; k++) begin
            if (int'(code) == SPEC_LO + k) hit = hit | spec_evt[k];
        end
    end

endmodule

// File: rtl/ecb_ctr_slice.sv
// Event counter: loads on write, otherwise adds one when run is high.
// ovf_rise flags that the coming increment sets the top bit from 0.
module ecb_ctr_slice #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         ovf_rise
);

    logic [W-1:0] nxt;

    // Incremented value, used for both the update and the edge detection.
    assign nxt      = cnt + W'(1);
    assign ovf_rise = run && !wr_en && !cnt[W-1] && nxt[W-1];

    // Count register: the write wins over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_en) cnt <= wdata;
        else if (run)   cnt <= nxt;
    end

endmodule

// File: rtl/ecb_cyc_ctr.sv
// Wide cycle counter, written in two halves. A write to either half
// suppresses the increment for that cycle. ovf_rise marks the top bit rising.
module ecb_cyc_ctr #(
    parameter int CYC_W  = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CYC_W-1:0]  cnt,
    output logic              ovf_rise
);

    localparam int HI_W = CYC_W - DATA_W;

    logic [CYC_W-1:0] nxt;

    // Incremented value and top-bit edge.
    assign nxt      = cnt + CYC_W'(1);
    assign ovf_rise = run && !wr_lo && !wr_hi && !cnt[CYC_W-1] && nxt[CYC_W-1];

    // Two-half register with write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt[CYC_W-1:DATA_W] <= wdata[HI_W-1:0];
        end else if (run) begin
            cnt <= nxt;
        end
    end

endmodule

// File: rtl/evt_ctr_bank.sv
// Freezable event counter bank.
// Holds counter 0 (cycles, CYC_W bits) and counters 1..N_CTR-1 (DATA_W bits,
// each selecting an event by code), with global and local freeze. A qualified
// overflow raises irq and sets freeze-all.
// Assumes DATA_W = 32 for the bit positions of the control words.
module evt_ctr_bank
    import evt_ctr_pkg::*;
#(
    parameter int N_CTR  = 11,
    parameter int DATA_W = 32,
    parameter int CYC_W  = 64,
    parameter int EVT_W  = 7,
    parameter int N_SPEC = 8,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic [N_REF-1:0]          ref_evt,
    input  logic [(N_CTR-1)*N_SPEC-1:0] spec_evt,
    output logic                      irq
);

    localparam int IDX_W = $clog2(N_CTR);
    localparam int HI_W  = CYC_W - DATA_W;

    reg_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic               g_fac, g_pmie, g_fcece;
    lca_t               lca [N_CTR];
    logic [DATA_W-1:0]  lcb [N_CTR];
    logic [DATA_W-1:0]  cnt_lo [N_CTR];
    logic [CYC_W-1:0]   cyc_q;
    logic [N_CTR-1:0]   ovf, msb, trig, wr_cnt, hit;
    logic [N_CTR-1:0]   ovf_flag;
    logic               wr_hi0;

    ecb_addr_dec #(.N_CTR(N_CTR), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr (addr),
        .kind (kind),
        .idx  (idx)
    );

    // Per-counter count-word write strobes.
    always_comb begin
        for (int n = 0; n < N_CTR; n++) begin
            wr_cnt[n] = wr_en && (kind == RK_CNT) && (int'(idx) == n);
        end
    end
    assign wr_hi0 = wr_en && (kind == RK_CNTHI);

    // Counter 0: free-running cycle counter.
    ecb_cyc_ctr #(.CYC_W(CYC_W), .DATA_W(DATA_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!g_fac && !lca[0].fc),
        .wr_lo    (wr_cnt[0]),
        .wr_hi    (wr_hi0),
        .wdata    (wdata),
        .cnt      (cyc_q),
        .ovf_rise (ovf[0])
    );
    assign cnt_lo[0] = cyc_q[DATA_W-1:0];
    assign msb[0]    = cyc_q[CYC_W-1];
    assign hit[0]    = 1'b1;

    // Counters 1..N_CTR-1: event selector plus counter slice.
    for (genvar n = 1; n < N_CTR; n++) begin : g_ctr
        ecb_evt_sel #(.EVT_W(EVT_W), .N_SPEC(N_SPEC)) u_sel (
            .code     (lca[n].evt),
            .ref_evt  (ref_evt),
            .spec_evt (spec_evt[(n-1)*N_SPEC +: N_SPEC]),
            .hit      (hit[n])
        );
        ecb_ctr_slice #(.W(DATA_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (!g_fac && !lca[n].fc && hit[n]),
            .wr_en    (wr_cnt[n]),
            .wdata    (wdata),
            .cnt      (cnt_lo[n]),
            .ovf_rise (ovf[n])
        );
        assign msb[n] = cnt_lo[n][DATA_W-1];
    end

    // Qualified overflow: all three enables must be set.
    always_comb begin
        for (int n = 0; n < N_CTR; n++) begin
            trig[n] = ovf[n] && lca[n].ce && g_pmie && g_fcece;
        end
    end

    // Global control word; a hardware freeze wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_fac   <= 1'b0;
            g_pmie  <= 1'b0;
            g_fcece <= 1'b0;
        end else begin
            if (wr_en && kind == RK_GCTL) begin
                g_fac   <= wdata[GB_FAC];
                g_pmie  <= wdata[GB_PMIE];
                g_fcece <= wdata[GB_FCECE];
            end
            if (|trig) g_fac <= 1'b1;
        end
    end

    // Local control words A and B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < N_CTR; n++) begin
                lca[n] <= '0;
                lcb[n] <= '0;
            end
        end else if (wr_en) begin
            for (int n = 0; n < N_CTR; n++) begin
                if (int'(idx) == n && kind == RK_CA) begin
                    lca[n].fc  <= wdata[LB_FC];
                    lca[n].ce  <= wdata[LB_CE];
                    lca[n].evt <= wdata[LB_EVT +: EVT_W];
                end
                if (int'(idx) == n && kind == RK_CB) lcb[n] <= wdata;
            end
        end
    end

    // Overflow flags: set on a qualified overflow, cleared once the monitor
    // is unfrozen and that counter's top bit is 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= '0;
        end else begin
            for (int n = 0; n < N_CTR; n++) begin
                if (trig[n])                  ovf_flag[n] <= 1'b1;
                else if (!g_fac && !msb[n])   ovf_flag[n] <= 1'b0;
            end
        end
    end

    assign irq = |ovf_flag;

    // Read multiplexer; unused bits read 0.
    always_comb begin
        rdata = '0;
        case (kind)
            RK_GCTL: begin
                rdata[GB_FAC]   = g_fac;
                rdata[GB_PMIE]  = g_pmie;
                rdata[GB_FCECE] = g_fcece;
            end
            RK_CNTHI: rdata[HI_W-1:0] = cyc_q[CYC_W-1:DATA_W];
            default: begin
                for (int n = 0; n < N_CTR; n++) begin
                    if (int'(idx) == n) begin
                        if (kind == RK_CA) begin
                            rdata[LB_FC]          = lca[n].fc;
                            rdata[LB_CE]          = lca[n].ce;
                            rdata[LB_EVT +: EVT_W] = lca[n].evt;
                        end
                        if (kind == RK_CB)  rdata = lcb[n];
                        if (kind == RK_CNT) rdata = cnt_lo[n];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/evt_ctr_bank_chk.sv
// Checker: temporal properties of the counter bank, bound to the top module.
module evt_ctr_bank_chk #(
    parameter int CYC_W  = 64,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              fac,
    input logic              pmie,
    input logic              fcece,
    input logic              fc0,
    input logic              fc1,
    input logic              irq,
    input logic [CYC_W-1:0]  cyc,
    input logic [DATA_W-1:0] c1
);

    // R2: unfrozen and unwritten, the cycle counter steps by one.
    assert_cyc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fac && !fc0 && !wr_en) |=> (cyc == $past(cyc) + CYC_W'(1)));

    // R4: a frozen counter holds its value when nothing is written.
    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((fac || fc1) && !wr_en) |=> $stable(c1));

    // R7: the interrupt arrives together with the hardware freeze.
    assert_irq_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> fac);

    // R8: no interrupt without both global enables.
    assert_irq_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pmie && fcece));

    // R9: the interrupt cannot drop while the monitor is still frozen.
    assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && fac) |=> irq);

endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.CYC_W(CYC_W), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .fac   (g_fac),
    .pmie  (g_pmie),
    .fcece (g_fcece),
    .fc0   (lca[0].fc),
    .fc1   (lca[1].fc),
    .irq   (irq),
    .cyc   (cyc_q),
    .c1    (cnt_lo[1])
);

// File: tb/evt_ctr_bank_tb_top.sv
// Bench for the event counter bank: a vector table for event decoding,
// then directed tests for reset, freeze, write priority, storage and overflow.
module evt_ctr_bank_tb_top;
    import evt_ctr_pkg::*;

    localparam int N_CTR  = 11;
    localparam int N_SPEC = 8;
    localparam int N_SP   = (N_CTR - 1) * N_SPEC;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [N_REF-1:0] ref_evt;
    logic [N_SP-1:0]  spec_evt;
    logic        irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    evt_ctr_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .ref_evt  (ref_evt),
        .spec_evt (spec_evt),
        .irq      (irq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Vector fields: ctr[28:25] code[24:18] isref[17] all[16] bit[15:8] exp[7:0]
    localparam logic [28:0] VEC [0:8] = '{
        {4'd1,  7'd12, 1'b1, 1'b0, 8'd0,  8'd3},
        {4'd5,  7'd63, 1'b1, 1'b0, 8'd51, 8'd3},
        {4'd2,  7'd64, 1'b0, 1'b0, 8'd8,  8'd3},
        {4'd10, 7'd71, 1'b0, 1'b0, 8'd79, 8'd3},
        {4'd7,  7'd65, 1'b0, 1'b0, 8'd49, 8'd3},
        {4'd8,  7'd64, 1'b0, 1'b0, 8'd64, 8'd0},
        {4'd3,  7'd5,  1'b1, 1'b1, 8'd0,  8'd0},
        {4'd4,  7'd72, 1'b0, 1'b1, 8'd0,  8'd0},
        {4'd6,  7'd11, 1'b1, 1'b1, 8'd0,  8'd0}
    };

    function automatic int ca(int n); return CTR_BASE + CTR_STRIDE * n;     endfunction
    function automatic int cb(int n); return CTR_BASE + CTR_STRIDE * n + 4; endfunction
    function automatic int cn(int n); return CTR_BASE + CTR_STRIDE * n + 8; endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        addr = 8'(a);
        #1;
        v = rdata;
    endtask

    task automatic pulse(bit isref, bit all, int b);
        @(negedge clk);
        if (all) begin
            ref_evt = '1; spec_evt = '1;
        end else if (isref) ref_evt[b] = 1'b1;
        else spec_evt[b] = 1'b1;
        @(negedge clk);
        ref_evt = '0; spec_evt = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        ref_evt = '0; spec_evt = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(GCTL_ADDR, v); chk("R1 gctl", v, 32'h0);
        rd(ca(1), v);     chk("R1 ctrlA", v, 32'h0);
        rd(cb(2), v);     chk("R1 ctrlB", v, 32'h0);
        rd(cn(3), v);     chk("R1 count", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'h00, v);     chk("R1 unmapped", v, 32'h0);

        // R2: cycle counter steps once per clock
        @(negedge clk); rd(cn(0), a);
        repeat (10) @(negedge clk); rd(cn(0), b);
        chk("R2 step", b - a, 32'd10);
        wr(ca(0), 32'h8000_0000);
        wr(cn(0) + 4, 32'd5);
        wr(cn(0), 32'hFFFF_FFFE);
        wr(ca(0), 32'h0);
        repeat (4) @(negedge clk);
        rd(cn(0), v);     chk("R2 carry low", v, 32'h2);
        rd(cn(0) + 4, v); chk("R2 carry high", v, 32'h6);

        // R3 / R5: event decoding vectors
        for (int i = 0; i < 9; i++) begin
            logic [28:0] e;
            int c;
            e = VEC[i];
            c = int'(e[28:25]);
            wr(ca(c), {9'b0, e[24:18], 16'b0});
            wr(cn(c), 32'h0);
            repeat (3) pulse(e[17], e[16], int'(e[15:8]));
            rd(cn(c), v);
            chk((e[7:0] == 0 && e[16]) ? "R5 unmapped code" : "R3 event select",
                v, {24'b0, e[7:0]});
        end

        // R4: global and local freeze
        wr(ca(1), 32'd12 << 16);
        wr(cn(1), 32'h0);
        ref_evt[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(cn(1), v); chk("R4 running", v, 32'd5);
        wr(GCTL_ADDR, 32'h8000_0000);
        rd(cn(1), a);
        rd(cn(0), b);
        repeat (5) @(negedge clk);
        rd(cn(1), v); chk("R4 global hold", v, a);
        rd(cn(0), v); chk("R4 cycle hold", v, b);
        wr(GCTL_ADDR, 32'h0);
        repeat (3) @(negedge clk);
        rd(cn(1), v); chk("R4 resume", v, a + 32'd3);
        wr(ca(1), 32'h8000_0000 | (32'd12 << 16));
        rd(cn(1), a);
        repeat (4) @(negedge clk);
        rd(cn(1), v); chk("R4 local hold", v, a);
        ref_evt[0] = 1'b0;

        // R6: write wins over increment, and loads while frozen
        wr(ca(1), 32'd12 << 16);
        @(negedge clk);
        ref_evt[0] = 1'b1; wr_en = 1'b1; addr = 8'(cn(1)); wdata = 32'd100;
        @(negedge clk);
        ref_evt[0] = 1'b0; wr_en = 1'b0;
        rd(cn(1), v); chk("R6 priority", v, 32'd100);
        wr(GCTL_ADDR, 32'h8000_0000);
        wr(cn(2), 32'h1234);
        rd(cn(2), v); chk("R6 frozen load", v, 32'h1234);
        wr(GCTL_ADDR, 32'h0);

        // R10: storage and readback masks
        wr(cb(4), 32'hDEAD_BEEF);
        rd(cb(4), v); chk("R10 ctrlB", v, 32'hDEAD_BEEF);
        rd(ca(4), v); chk("R10 ctrlA untouched", v, 32'h0048_0000);
        wr(ca(5), 32'hFFFF_FFFF);
        rd(ca(5), v); chk("R10 ctrlA mask", v, 32'h847F_0000);
        wr(ca(5), 32'h0);
        wr(GCTL_ADDR, 32'hFFFF_FFFF);
        rd(GCTL_ADDR, v); chk("R10 gctl mask", v, 32'hE000_0000);
        wr(GCTL_ADDR, 32'h0);

        // R8: missing local enable
        wr(ca(1), 32'd12 << 16);
        wr(GCTL_ADDR, 32'h6000_0000);
        wr(cn(1), 32'h7FFF_FFFE);
        repeat (2) pulse(1'b1, 1'b0, 0);
        rd(cn(1), v);     chk("R8 reached msb", v, 32'h8000_0000);
        chk("R8 no irq local", {31'b0, irq}, 32'h0);
        rd(GCTL_ADDR, v); chk("R8 no freeze", v, 32'h6000_0000);
        // R8: missing freeze-on-condition
        wr(ca(1), 32'h0400_0000 | (32'd12 << 16));
        wr(GCTL_ADDR, 32'h4000_0000);
        wr(cn(1), 32'h7FFF_FFFE);
        repeat (2) pulse(1'b1, 1'b0, 0);
        chk("R8 no irq global", {31'b0, irq}, 32'h0);

        // R7: qualified overflow
        wr(GCTL_ADDR, 32'h6000_0000);
        wr(cn(1), 32'h7FFF_FFFE);
        pulse(1'b1, 1'b0, 0);
        chk("R7 not yet", {31'b0, irq}, 32'h0);
        pulse(1'b1, 1'b0, 0);
        chk("R7 irq", {31'b0, irq}, 32'h1);
        rd(GCTL_ADDR, v); chk("R7 hw freeze", v, 32'hE000_0000);
        pulse(1'b1, 1'b0, 0);
        rd(cn(1), v);     chk("R7 held", v, 32'h8000_0000);
        rd(cn(0), a);
        repeat (3) @(negedge clk);
        rd(cn(0), v);     chk("R7 cycle held", v, a);

        // R9: unfreeze first, then clear the top bit
        wr(GCTL_ADDR, 32'h6000_0000);
        chk("R9 msb still set", {31'b0, irq}, 32'h1);
        wr(cn(1), 32'h0);
        chk("R9 one cycle later", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R9 cleared", {31'b0, irq}, 32'h0);
        // R9: clear the top bit first, then unfreeze
        wr(cn(1), 32'h7FFF_FFFF);
        pulse(1'b1, 1'b0, 0);
        chk("R9 retrigger", {31'b0, irq}, 32'h1);
        wr(cn(1), 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 still frozen", {31'b0, irq}, 32'h1);
        wr(GCTL_ADDR, 32'h6000_0000);
        @(negedge clk);
        chk("R9 cleared after unfreeze", {31'b0, irq}, 32'h0);

        // R11: cycle counter overflow at the top bit
        wr(GCTL_ADDR, 32'h0);
        wr(ca(0), 32'h8000_0000);
        wr(cn(0) + 4, 32'h7FFF_FFFF);
        wr(cn(0), 32'hFFFF_FFF0);
        wr(GCTL_ADDR, 32'h6000_0000);
        wr(ca(0), 32'h0400_0000);
        repeat (20) @(negedge clk);
        chk("R11 irq", {31'b0, irq}, 32'h1);
        rd(cn(0) + 4, v); chk("R11 high", v, 32'h8000_0000);
        rd(cn(0), v);     chk("R11 low", v, 32'h0);

        done = 1;
        summary();
        $finish;
    end

endmodule